// File: doc/BRIEF.md
# Immediate extension prefix unit

This unit belongs to the decode stage of a processor whose instructions are all 16 bits wide. Such an instruction set can only hold short immediates, so a separate prefix instruction carries a 13-bit payload that widens the immediate of the instruction after it. The unit watches the decoded stream, remembers the payloads of a run of prefixes, and when the next ordinary instruction arrives, builds that instruction's full 32-bit operand. How the payloads and the short field are combined depends on a target-class code that the decoder supplies with each instruction.

At most two prefixes count. In a run of three or more, the unit keeps the first and the last and drops the ones between them. Stack-relative displacements are scaled by the access size. For two-register ALU operations, a prefix turns the operation into a register-plus-immediate form. The unit signals this on a separate output. It carries out no instruction, reads no register and computes no branch target.

A small state machine holds the prefix count. Its states are EMPTY (no prefix held), ONE (first payload held) and TWO (first and last payloads held). Its transitions are:
- take_first: EMPTY to ONE on a prefix.
- take_second: ONE to TWO on a prefix.
- replace_last: TWO to TWO on a prefix. The new payload overwrites the last payload and the first is kept.
- consume: any state to EMPTY on a valid ordinary instruction.
- drop: any state to EMPTY on a flush or a reset.

Cycles with the valid strobe low leave the state unchanged.

Top module: `ext_imm_unit`

## Requirements
- R1: A synchronous reset (`rst`) or a `flush` empties the prefix state and clears the stored payloads. An instruction presented in the same cycle as a flush is dropped and produces no output. The next target after a reset or flush sees no prefix.
- R2: In a run of three or more prefixes, the result is the same as for exactly two prefixes, using the first payload of the run and the payload just before the target.
- R3: Class 1, unsigned immediate, uses `in_short[5:0]` as imm6. No prefix gives imm6 zero-extended. One prefix gives {p1, imm6} zero-extended from 19 bits. Two prefixes give {p1, p2, imm6}.
- R4: Class 2, signed immediate, builds the same patterns as R3 but sign-extends them from bit 5, bit 18 or bit 31.
- R5: Class 3, stack displacement, uses `in_size`: 0 means byte, 1 means half word, 2 or 3 means word. With no prefix the result is imm6 shifted left by 0, 1 or 2. With one or two prefixes the result is {p1, imm6} or {p1, p2, imm6} with the low 0, 1 or 2 bits of imm6 forced to zero. The result is zero-extended.
- R6: Class 4, register indirect, gives 0 with no prefix, p1 zero-extended with one prefix, and {p1, p2} zero-extended with two prefixes.
- R7: Class 5, register indirect with post-increment, always gives 0 and ignores any prefix.
- R8: Class 6, two-register ALU operation, gives value 0 and `out_use_imm`=0 with no prefix. With prefixes it gives `out_use_imm`=1 and a value of p1 or {p1, p2}, zero-extended.
- R9: Class 7, PC-relative branch, takes `in_short[7:0]` as a signed 8-bit offset s8. No prefix gives {s8, 0} sign-extended from 9 bits. One prefix gives {p1, s8, 0} sign-extended from 22 bits. Two prefixes give the low 32 bits of {p1, p2, s8, 0}.
- R10: Class 0, non-extendable, gives value 0. Any pending prefixes are discarded and have no effect on later instructions.
- R11: `out_valid` rises exactly one clock after a valid ordinary instruction is accepted, and at no other time. While `out_valid` is low, `out_value` and `out_use_imm` are 0. `out_use_imm` is 1 only for class 6 with at least one prefix.
- R12: A prefix instruction produces no output. Cycles with `in_valid` low keep the pending prefix state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Pipeline flush, drops pending prefixes and the current instruction |
| in_valid | input | 1 | Decoded instruction present |
| in_is_prefix | input | 1 | Instruction is an extension prefix |
| in_payload | input | 13 | Prefix immediate payload |
| in_class | input | 3 | Target class code 0..7 (see requirements) |
| in_short | input | 8 | Target's short immediate field (imm6 in [5:0], s8 in [7:0]) |
| in_size | input | 2 | Access size: 0 byte, 1 half word, 2/3 word |
| out_value | output | 32 | Built immediate or displacement |
| out_use_imm | output | 1 | Operate rs with the immediate instead of rd and rs |
| out_valid | output | 1 | Output fields carry a result |

## Verification
On every cycle, the assertions check the state machine's moves: take_first captures the payload, replace_last keeps the first payload, consume and drop return to EMPTY, and a flush clears both payload registers. They also check the output timing: a one-cycle lag from accept to `out_valid`, silent prefixes, zeroed fields while idle, and `out_use_imm` for class 6 with a prefix. The exact merged values are checked only by the bench's scenarios, which compare every cycle against a queue-based model. These values cover each class's sign and zero extension, the truncation of the stack-displacement low bits by size, the 35-to-32-bit cut for branches, and which payloads survive a long prefix run. Flushes and resets that land in the middle of a prefix run are also exercised only by those scenarios.

// File: rtl/ext_pkg.sv
package ext_pkg;

    typedef enum logic [2:0] {
        CL_PLAIN = 3'd0,
        CL_UIMM  = 3'd1,
        CL_SIMM  = 3'd2,
        CL_SPREL = 3'd3,
        CL_RIND  = 3'd4,
        CL_RPOST = 3'd5,
        CL_RR    = 3'd6,
        CL_BR    = 3'd7
    } tgt_class_e;

    typedef enum logic [1:0] {
        PS_EMPTY = 2'd0,
        PS_ONE   = 2'd1,
        PS_TWO   = 2'd2
    } pfx_state_e;

endpackage

// File: rtl/ext_prefix_track.sv
module ext_prefix_track
    import ext_pkg::*;
#(
    parameter int PFX_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    input  logic             in_is_prefix,
    input  logic [PFX_W-1:0] in_payload,
    output pfx_state_e       state_o,
    output logic [PFX_W-1:0] first_o,
    output logic [PFX_W-1:0] last_o
);

    pfx_state_e       state_q, state_d;
    logic [PFX_W-1:0] first_q, last_q;
    logic             take_pfx, take_tgt;

    assign take_pfx = in_valid && in_is_prefix && !flush;
    assign take_tgt = in_valid && !in_is_prefix && !flush;

    // next-state selection
    always_comb begin
        state_d = state_q;
        if (flush) begin
            state_d = PS_EMPTY;                      // drop
        end else if (in_valid) begin
            if (in_is_prefix) begin
                unique case (state_q)
                    PS_EMPTY: state_d = PS_ONE;      // take_first
                    PS_ONE:   state_d = PS_TWO;      // take_second
                    PS_TWO:   state_d = PS_TWO;      // replace_last
                    default:  state_d = PS_EMPTY;
                endcase
            end else begin
                state_d = PS_EMPTY;                  // consume
            end
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= PS_EMPTY;
        else     state_q <= state_d;
    end

    // payload registers
    always_ff @(posedge clk) begin
        if (rst || flush || take_tgt) begin
            first_q <= '0;
            last_q  <= '0;
        end else if (take_pfx) begin
            unique case (state_q)
                PS_EMPTY: first_q <= in_payload;
                PS_ONE,
                PS_TWO:   last_q  <= in_payload;
                default:  first_q <= in_payload;
            endcase
        end
    end

    assign state_o = state_q;
    assign first_o = first_q;
    assign last_o  = last_q;

    // R1: flush empties state and payloads
    a_r1_flush_clears: assert property (@(posedge clk) disable iff (rst)
        flush |=> (state_q == PS_EMPTY && first_q == '0 && last_q == '0));

    // R2: a prefix in TWO keeps the first payload and replaces the last
    a_r2_first_kept: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_TWO && take_pfx) |=>
        (state_q == PS_TWO && first_q == $past(first_q) && last_q == $past(in_payload)));

    // R12: first prefix is captured
    a_r12_take_first: assert property (@(posedge clk) disable iff (rst)
        (state_q == PS_EMPTY && take_pfx) |=>
        (state_q == PS_ONE && first_q == $past(in_payload)));

    // R10: any target consumes the pending prefixes
    a_r10_consume: assert property (@(posedge clk) disable iff (rst)
        take_tgt |=> (state_q == PS_EMPTY));

    // R12: bubbles hold the state
    a_r12_bubble_hold: assert property (@(posedge clk) disable iff (rst)
        (!in_valid && !flush) |=> $stable(state_q) && $stable(first_q) && $stable(last_q));

endmodule

// File: rtl/ext_value_merge.sv
module ext_value_merge
    import ext_pkg::*;
#(
    parameter int PFX_W   = 13,
    parameter int SHORT_W = 6,
    parameter int BR_W    = 8,
    parameter int OUT_W   = 32
) (
    input  pfx_state_e       state_i,
    input  logic [PFX_W-1:0] first_i,
    input  logic [PFX_W-1:0] last_i,
    input  tgt_class_e       cls_i,
    input  logic [BR_W-1:0]  short_i,
    input  logic [1:0]       size_i,
    output logic [OUT_W-1:0] value_o,
    output logic             use_imm_o
);

    localparam int WIDE   = 2*PFX_W + BR_W + 1;
    localparam int W_ONE  = PFX_W + SHORT_W;
    localparam int W_TWO  = 2*PFX_W + SHORT_W;
    localparam int B_NONE = BR_W + 1;
    localparam int B_ONE  = PFX_W + BR_W + 1;

    function automatic logic [WIDE-1:0] sx(input logic [WIDE-1:0] v, input int n);
        logic [WIDE-1:0] m;
        m = {WIDE{1'b1}} << n;
        return v[n-1] ? (v | m) : (v & ~m);
    endfunction

    logic [WIDE-1:0]    f_w, l_w, imm_w, br_w, mask_w, imm_cut;
    logic [WIDE-1:0]    cat0, cat1, cat2, res;
    logic [1:0]         shamt;

    always_comb begin
        f_w     = WIDE'(first_i);
        l_w     = WIDE'(last_i);
        imm_w   = WIDE'(short_i[SHORT_W-1:0]);
        br_w    = WIDE'(short_i) << 1;
        shamt   = (size_i == 2'd0) ? 2'd0 : (size_i == 2'd1) ? 2'd1 : 2'd2;
        mask_w  = {WIDE{1'b1}} << shamt;
        imm_cut = imm_w & mask_w;
        cat0    = imm_w;
        cat1    = (f_w << SHORT_W) | imm_w;
        cat2    = (f_w << (PFX_W + SHORT_W)) | (l_w << SHORT_W) | imm_w;
        res       = '0;
        use_imm_o = 1'b0;
        unique case (cls_i)
            CL_PLAIN: res = '0;
            CL_UIMM: begin
                unique case (state_i)
                    PS_EMPTY: res = cat0;
                    PS_ONE:   res = cat1;
                    default:  res = cat2;
                endcase
            end
            CL_SIMM: begin
                unique case (state_i)
                    PS_EMPTY: res = sx(cat0, SHORT_W);
                    PS_ONE:   res = sx(cat1, W_ONE);
                    default:  res = sx(cat2, W_TWO);
                endcase
            end
            CL_SPREL: begin
                unique case (state_i)
                    PS_EMPTY: res = imm_w << shamt;
                    PS_ONE:   res = (f_w << SHORT_W) | imm_cut;
                    default:  res = (f_w << (PFX_W + SHORT_W)) | (l_w << SHORT_W) | imm_cut;
                endcase
            end
            CL_RIND, CL_RR: begin
                unique case (state_i)
                    PS_EMPTY: res = '0;
                    PS_ONE:   res = f_w;
                    default:  res = (f_w << PFX_W) | l_w;
                endcase
                use_imm_o = (cls_i == CL_RR) && (state_i != PS_EMPTY);
            end
            CL_RPOST: res = '0;
            CL_BR: begin
                unique case (state_i)
                    PS_EMPTY: res = sx(br_w, B_NONE);
                    PS_ONE:   res = sx((f_w << (BR_W + 1)) | br_w, B_ONE);
                    default:  res = (f_w << (PFX_W + BR_W + 1)) | (l_w << (BR_W + 1)) | br_w;
                endcase
            end
            default: res = '0;
        endcase
        value_o = res[OUT_W-1:0];
    end

endmodule

// File: rtl/ext_imm_unit.sv
module ext_imm_unit
    import ext_pkg::*;
#(
    parameter int PFX_W   = 13,
    parameter int SHORT_W = 6,
    parameter int BR_W    = 8,
    parameter int OUT_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             in_valid,
    input  logic             in_is_prefix,
    input  logic [PFX_W-1:0] in_payload,
    input  logic [2:0]       in_class,
    input  logic [BR_W-1:0]  in_short,
    input  logic [1:0]       in_size,
    output logic [OUT_W-1:0] out_value,
    output logic             out_use_imm,
    output logic             out_valid
);

    pfx_state_e       st;
    logic [PFX_W-1:0] p_first, p_last;
    logic [OUT_W-1:0] merged;
    logic             merged_ui;
    logic             accept;
    tgt_class_e       cls;

    assign cls    = tgt_class_e'(in_class);
    assign accept = in_valid && !in_is_prefix && !flush;

    ext_prefix_track #(.PFX_W(PFX_W)) u_track (
        .clk          (clk),
        .rst          (rst),
        .flush        (flush),
        .in_valid     (in_valid),
        .in_is_prefix (in_is_prefix),
        .in_payload   (in_payload),
        .state_o      (st),
        .first_o      (p_first),
        .last_o       (p_last)
    );

    ext_value_merge #(
        .PFX_W   (PFX_W),
        .SHORT_W (SHORT_W),
        .BR_W    (BR_W),
        .OUT_W   (OUT_W)
    ) u_merge (
        .state_i   (st),
        .first_i   (p_first),
        .last_i    (p_last),
        .cls_i     (cls),
        .short_i   (in_short),
        .size_i    (in_size),
        .value_o   (merged),
        .use_imm_o (merged_ui)
    );

    // output register
    always_ff @(posedge clk) begin
        if (rst || !accept) begin
            out_valid   <= 1'b0;
            out_value   <= '0;
            out_use_imm <= 1'b0;
        end else begin
            out_valid   <= 1'b1;
            out_value   <= merged;
            out_use_imm <= merged_ui;
        end
    end

    // R11: result appears one clock after an accepted target
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (rst)
        accept |=> out_valid);

    // R11 / R1: nothing appears without an accepted target
    a_r11_no_spurious: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !out_valid);

    // R12: a prefix yields no output
    a_r12_prefix_silent: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_is_prefix) |=> !out_valid);

    // R11: fields zero while idle
    a_r11_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (out_value == '0 && !out_use_imm));

    // R8: two-register op with a pending prefix selects the immediate form
    a_r8_rr_use_imm: assert property (@(posedge clk) disable iff (rst)
        (accept && cls == CL_RR && st != PS_EMPTY) |=> out_use_imm);

    // R7: post-increment target ignores prefixes
    a_r7_post_zero: assert property (@(posedge clk) disable iff (rst)
        (accept && cls == CL_RPOST) |=> (out_value == '0 && !out_use_imm));

endmodule

// File: tb/sim_ext_imm_unit.sv
module sim_ext_imm_unit;

    logic        clk = 1'b0;
    logic        rst, flush, in_valid, in_is_prefix;
    logic [12:0] in_payload;
    logic [2:0]  in_class;
    logic [7:0]  in_short;
    logic [1:0]  in_size;
    logic [31:0] out_value;
    logic        out_use_imm, out_valid;

    always #4 clk = ~clk;

    ext_imm_unit u0 (
        .clk(clk), .rst(rst), .flush(flush), .in_valid(in_valid),
        .in_is_prefix(in_is_prefix), .in_payload(in_payload),
        .in_class(in_class), .in_short(in_short), .in_size(in_size),
        .out_value(out_value), .out_use_imm(out_use_imm), .out_valid(out_valid)
    );

    int compared = 0;
    int mismatched = 0;
    bit started = 0;
    bit done = 0;

    longint unsigned q[$];
    logic [31:0] exp_value = '0;
    bit          exp_ui = 0;
    bit          exp_valid = 0;
    string       exp_req = "R1";

    function automatic longint unsigned sxt(longint unsigned x, int w);
        if ((x >> (w - 1)) & 1) return x | (~64'd0 << w);
        return x;
    endfunction

    function automatic void ref_calc(input int cls, input int n,
                                     input longint unsigned f, input longint unsigned l,
                                     input longint unsigned sh8, input int sz,
                                     output longint unsigned v, output bit ui);
        longint unsigned i6, m;
        int sh;
        i6 = sh8 & 63;
        sh = (sz == 0) ? 0 : (sz == 1) ? 1 : 2;
        ui = 0;
        v  = 0;
        case (cls)
            1: v = (n == 0) ? i6 : (n == 1) ? ((f << 6) | i6) : ((f << 19) | (l << 6) | i6);
            2: v = (n == 0) ? sxt(i6, 6) : (n == 1) ? sxt((f << 6) | i6, 19)
                             : ((f << 19) | (l << 6) | i6);
            3: begin
                m = i6 & ~((64'd1 << sh) - 1);
                v = (n == 0) ? (i6 << sh) : (n == 1) ? ((f << 6) | m)
                             : ((f << 19) | (l << 6) | m);
            end
            4, 6: begin
                v  = (n == 0) ? 0 : (n == 1) ? f : ((f << 13) | l);
                ui = (cls == 6) && (n > 0);
            end
            7: v = (n == 0) ? sxt(sh8 << 1, 9) : (n == 1) ? sxt((f << 9) | (sh8 << 1), 22)
                             : ((f << 22) | (l << 9) | (sh8 << 1));
            default: v = 0;
        endcase
        v = v & 64'hFFFF_FFFF;
    endfunction

    // behavioural reference model
    always @(posedge clk) begin
        longint unsigned v;
        bit ui;
        int n;
        started <= 1;
        if (rst || flush) begin
            q.delete();
            exp_valid <= 0; exp_value <= '0; exp_ui <= 0; exp_req <= "R1";
        end else if (in_valid && in_is_prefix) begin
            q.push_back(longint'(in_payload));
            exp_valid <= 0; exp_value <= '0; exp_ui <= 0; exp_req <= "R12";
        end else if (in_valid) begin
            n = q.size();
            ref_calc(int'(in_class), (n > 2) ? 2 : n,
                     (n > 0) ? q[0] : 0, (n > 1) ? q[$] : 0,
                     longint'(in_short), int'(in_size), v, ui);
            q.delete();
            exp_valid <= 1; exp_value <= v[31:0]; exp_ui <= ui;
            if (n > 2) exp_req <= "R2";
            else case (in_class)
                3'd0: exp_req <= "R10";
                3'd1: exp_req <= "R3";
                3'd2: exp_req <= "R4";
                3'd3: exp_req <= "R5";
                3'd4: exp_req <= "R6";
                3'd5: exp_req <= "R7";
                3'd6: exp_req <= "R8";
                default: exp_req <= "R9";
            endcase
        end else begin
            exp_valid <= 0; exp_value <= '0; exp_ui <= 0; exp_req <= "R12";
        end
    end

    // compare every cycle, away from the active edge
    always @(negedge clk) begin
        if (started && !done) begin
            compared++;
            if (out_valid !== exp_valid || out_value !== exp_value || out_use_imm !== exp_ui) begin
                mismatched++;
                $display("FAIL %s/R11 t=%0t: got valid=%0b value=%h use_imm=%0b, expected valid=%0b value=%h use_imm=%0b",
                         exp_req, $time, out_valid, out_value, out_use_imm,
                         exp_valid, exp_value, exp_ui);
            end
        end
    end

    task automatic idle();
        @(negedge clk);
        in_valid = 0; in_is_prefix = 0; flush = 0; rst = 0;
    endtask

    task automatic pfx(input logic [12:0] p);
        @(negedge clk);
        rst = 0; flush = 0; in_valid = 1; in_is_prefix = 1; in_payload = p;
        in_class = 3'($urandom); in_short = 8'($urandom); in_size = 2'($urandom);
    endtask

    task automatic tgt(input logic [2:0] c, input logic [7:0] s, input logic [1:0] z);
        @(negedge clk);
        rst = 0; flush = 0; in_valid = 1; in_is_prefix = 0;
        in_payload = 13'($urandom); in_class = c; in_short = s; in_size = z;
    endtask

    task automatic do_flush();
        @(negedge clk);
        rst = 0; flush = 1; in_valid = 1; in_is_prefix = 0; in_class = 3'd1;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            mismatched++;
            $display("FAIL R11 watchdog expired: got running, expected finished");
            finish_run();
        end
    end

    initial begin
        rst = 1; flush = 0; in_valid = 0; in_is_prefix = 0;
        in_payload = '0; in_class = '0; in_short = '0; in_size = '0;
        repeat (3) @(negedge clk);
        idle();   // R1 reset state compared here

        // each class with 0..3 prefixes and every size
        for (int c = 0; c < 8; c++) begin
            for (int n = 0; n < 4; n++) begin
                for (int z = 0; z < 4; z++) begin
                    for (int k = 0; k < n; k++) pfx(13'($urandom));
                    tgt(3'(c), 8'($urandom), 2'(z));
                end
            end
        end

        // sign corners: R4 and R9 with MSB-set payloads and short fields
        pfx(13'h1000); tgt(3'd2, 8'h00, 2'd0);
        tgt(3'd2, 8'h20, 2'd0);
        pfx(13'h1FFF); pfx(13'h0000); tgt(3'd2, 8'h3F, 2'd0);
        tgt(3'd7, 8'h80, 2'd0);
        pfx(13'h1000); tgt(3'd7, 8'h7F, 2'd0);
        pfx(13'h1FFF); pfx(13'h1FFF); tgt(3'd7, 8'hFF, 2'd0);

        // R5 truncation of imm6 low bits
        pfx(13'h0001); tgt(3'd3, 8'h3F, 2'd1);
        pfx(13'h0001); tgt(3'd3, 8'h3F, 2'd2);
        tgt(3'd3, 8'h3F, 2'd2);

        // R2 long run with bubbles inside (R12)
        pfx(13'h0AAA); idle(); pfx(13'h1111); pfx(13'h0222); idle(); pfx(13'h0333);
        tgt(3'd1, 8'h15, 2'd0);

        // R10 prefixes discarded by a non-extendable target
        pfx(13'h1234); tgt(3'd0, 8'h11, 2'd0); tgt(3'd1, 8'h05, 2'd0);

        // R1 flush mid-run, and flush dropping a target
        pfx(13'h0F0F); do_flush(); tgt(3'd4, 8'h00, 2'd0);
        pfx(13'h0F0F); pfx(13'h0101); do_flush(); tgt(3'd6, 8'h00, 2'd0);

        // R1 reset mid-run
        pfx(13'h0777);
        @(negedge clk); rst = 1; in_valid = 0;
        tgt(3'd6, 8'h00, 2'd0);

        // random mixed traffic
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom % 16);
            if (r < 5)       pfx(13'($urandom));
            else if (r < 12) tgt(3'($urandom), 8'($urandom), 2'($urandom));
            else if (r < 15) idle();
            else             do_flush();
        end
        idle(); idle();
        @(negedge clk);
        finish_run();
    end

endmodule